// File: doc/BRIEF.md
# Clocked Bus Fault Injector

A synchronous pass-through stage placed in series with a multi-bit bus in a verification or fault-tolerance path. Under a small set of configuration inputs it either forwards the bus with one register of latency or corrupts selected value updates. The available corruptions are holding back the update, a short glitch to the previous value, inversion of every bit, and freezing the output on the previous value. Every change of any bit of the input bus is a start event. There is no notion of a return edge or a resting level.

An event counter applies the corruption on the first start event after reset and then on every Nth one. A free-running LFSR supplies cycle counts for the delay and the glitch or freeze width whenever a range is configured rather than a single value. All configuration is taken from the ports at the cycle of the start event, so the configuration can be changed freely between events.

Top module: `bus_fault_injector`

## Requirements
- R1: While reset is asserted and on the first edge after it, `busOut` is all zeros, the event counter is at its first slot, and no corruption is pending.
- R2: With `cfgMode` = 0 (pass) and nothing pending, `busOut` equals `busIn` delayed by exactly one clock.
- R3: `cfgMode` = 3 (jitter, not supported on a bus) and the unused code 7 behave as pass: every update reaches `busOut` one clock later whatever the delay and width inputs hold.
- R4: A start event is any clock where `busIn` differs in any bit from its value one clock earlier. The counter counts start events in every mode. The first start event after reset is eligible for corruption, and then every `cfgInterval`-th one. A `cfgInterval` of 0 acts as 1.
- R5: In delay mode (`cfgMode` = 2), an eligible update with drawn delay D keeps the previous value on `busOut` for D clocks, counting the clock of the event. The clock after that shows the current input. D = 0 is plain pass.
- R6: In delay mode, a start event that is not eligible, arriving while a delay is pending, cancels that delay. Its value appears one clock later as in pass.
- R7: In glitch mode (`cfgMode` = 1), with drawn delay D and width W, `busOut` shows the new value, then after D clocks shows the previous value for W clocks, then follows the input again. W = 0 gives no glitch.
- R8: In invert mode (`cfgMode` = 4), `busOut` is the bitwise complement of `busIn` one clock later, from the first clock the mode is seen. After leaving the mode, the complement persists until the next start event, which is forwarded uninverted.
- R9: In freeze modes (`cfgMode` = 5 or 6, identical), an eligible update holds the previous value on `busOut` for the drawn width W, counting the event clock. It then shows the current input. Input changes during the hold are ignored: they are neither corrupted nor counted by the interval counter.
- R10: A delay or width is drawn at random in [min, max] inclusive only when max is nonzero and greater than min. Otherwise the min value is used exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgMode | input | 3 | Corruption kind: 0 pass, 1 glitch, 2 delay, 3 jitter (pass), 4 invert, 5/6 freeze |
| cfgDelayMin | input | CNT_W | Lower bound of the delay in clocks |
| cfgDelayMax | input | CNT_W | Upper bound of the delay in clocks |
| cfgWidthMin | input | CNT_W | Lower bound of glitch or freeze width in clocks |
| cfgWidthMax | input | CNT_W | Upper bound of glitch or freeze width in clocks |
| cfgInterval | input | CNT_W | Corrupt one start event out of this many |
| busIn | input | WIDTH | Bus from the driver |
| busOut | output | WIDTH | Registered, possibly corrupted bus |

## Verification
The bench builds the block with WIDTH = 12 and CNT_W = 6. A 12-bit bus makes the full-width complement and the detection of a change in an upper bit easy to observe against the defaults. Six-bit counts keep every delay, width and interval window short enough to walk through cycle by cycle. They still leave room for random ranges, inverted bounds and an interval of 0. The LFSR keeps its default seed, so repeated random delays are checked against their bounds and for variation rather than for exact values.

// File: rtl/fi_pkg.sv
package fi_pkg;

  // Mode codes seen on the cfgMode port
  typedef enum logic [2:0] {
    FI_BYPASS    = 3'd0,
    FI_PULSE     = 3'd1,
    FI_DELAY     = 3'd2,
    FI_JITTER    = 3'd3,
    FI_INVERT    = 3'd4,
    FI_STUCK_OLD = 3'd5,
    FI_STUCK_NEW = 3'd6
  } fi_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_HOLD
  } fi_state_e;

  typedef enum logic [1:0] {
    KIND_DELAY,
    KIND_PULSE,
    KIND_STUCK
  } fi_kind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic useSaved;  // drive the pre-event value this clock
    logic capture;   // this clock is an accepted start; latch pre-event value
    logic invert;    // complement the forwarded value
  } fi_strobe_t;

  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;

endpackage

// File: rtl/fi_datapath.sv
module fi_datapath
  import fi_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] busIn,
  input  fi_strobe_t       strb,
  output logic             changed,
  output logic [WIDTH-1:0] busOut
);

  logic [WIDTH-1:0] prevIn;
  logic [WIDTH-1:0] savedVal;
  logic [WIDTH-1:0] nextOut;

  // Full-width comparison against the previous sample
  assign changed = (busIn != prevIn);

  always_comb begin
    if (strb.useSaved) begin
      nextOut = strb.capture ? prevIn : savedVal;
    end else if (strb.invert) begin
      nextOut = ~busIn;
    end else begin
      nextOut = busIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevIn   <= '0;
      savedVal <= '0;
      busOut   <= '0;
    end else begin
      prevIn <= busIn;
      if (strb.capture) begin
        savedVal <= prevIn;
      end
      busOut <= nextOut;
    end
  end

endmodule

// File: rtl/fi_ctrl.sv
module fi_ctrl
  import fi_pkg::*;
#(
  parameter int                CNT_W = 8,
  parameter logic [LFSR_W-1:0] SEED  = 16'hACE1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             changed,
  input  logic [2:0]       cfgMode,
  input  logic [CNT_W-1:0] cfgDelayMin,
  input  logic [CNT_W-1:0] cfgDelayMax,
  input  logic [CNT_W-1:0] cfgWidthMin,
  input  logic [CNT_W-1:0] cfgWidthMax,
  input  logic [CNT_W-1:0] cfgInterval,
  output fi_strobe_t       strb,
  output logic             ctrlIdle,
  output logic             invLatch,
  output logic             drawFire,
  output logic [CNT_W-1:0] drawDelay
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  fi_state_e        state, stateNext;
  fi_kind_e         kind, kindNext;
  logic [CNT_W-1:0] rem, remNext;
  logic [CNT_W-1:0] widthReg, widthNext;
  logic [CNT_W-1:0] evtCnt, evtCntNext;
  logic [CNT_W-1:0] cntInc;
  logic [CNT_W-1:0] intervalEff;
  logic [CNT_W-1:0] drawWidth;
  logic [LFSR_W-1:0] lfsr;
  fi_mode_e         mode;
  logic             stuckHold;
  logic             startEvt;
  logic             injMode;
  logic             startInj;
  logic             invNext;

  // Draw in [lo, hi] when the range is enabled, else lo exactly
  function automatic logic [CNT_W-1:0] pickCount(
    input logic [CNT_W-1:0]  lo,
    input logic [CNT_W-1:0]  hi,
    input logic [LFSR_W-1:0] rnd
  );
    logic [LFSR_W-1:0] span;
    logic [LFSR_W-1:0] offs;
    span = '0;
    offs = '0;
    if (hi != '0 && hi > lo) begin
      span = LFSR_W'(hi) - LFSR_W'(lo) + LFSR_W'(1);
      offs = rnd % span;
      return lo + offs[CNT_W-1:0];
    end
    return lo;
  endfunction

  assign mode        = fi_mode_e'(cfgMode);
  assign stuckHold   = (state == ST_HOLD) && (kind == KIND_STUCK);
  assign startEvt    = changed && !stuckHold;
  assign intervalEff = (cfgInterval == '0) ? ONE : cfgInterval;
  assign injMode     = (mode == FI_PULSE) || (mode == FI_DELAY) ||
                       (mode == FI_STUCK_OLD) || (mode == FI_STUCK_NEW);
  assign startInj    = startEvt && (evtCnt == '0) && injMode;
  assign drawDelay   = pickCount(cfgDelayMin, cfgDelayMax, lfsr);
  assign drawWidth   = pickCount(cfgWidthMin, cfgWidthMax,
                                 {lfsr[LFSR_W/2-1:0], lfsr[LFSR_W-1:LFSR_W/2]});
  assign cntInc      = evtCnt + ONE;
  assign ctrlIdle    = (state == ST_IDLE);
  assign drawFire    = startInj;

  // Interval slot counter
  always_comb begin
    evtCntNext = evtCnt;
    if (startEvt) begin
      evtCntNext = (cntInc >= intervalEff) ? '0 : cntInc;
    end
  end

  // Inversion: immediate on entry, released on the next bus change
  always_comb begin
    if (mode == FI_INVERT) begin
      invNext = 1'b1;
    end else if (changed) begin
      invNext = 1'b0;
    end else begin
      invNext = invLatch;
    end
  end

  // Injection sequencer
  always_comb begin
    stateNext     = state;
    kindNext      = kind;
    remNext       = rem;
    widthNext     = widthReg;
    strb.useSaved = 1'b0;
    strb.capture  = 1'b0;
    strb.invert   = (mode == FI_INVERT) || (invLatch && !changed);
    if (startInj) begin
      strb.capture = 1'b1;
      unique case (mode)
        FI_DELAY: begin
          kindNext = KIND_DELAY;
          if (drawDelay == '0) begin
            stateNext = ST_IDLE;
          end else begin
            strb.useSaved = 1'b1;
            stateNext     = ST_HOLD;
            remNext       = drawDelay - ONE;
          end
        end
        FI_PULSE: begin
          kindNext = KIND_PULSE;
          if (drawDelay != '0) begin
            stateNext = ST_WAIT;
            remNext   = drawDelay - ONE;
            widthNext = drawWidth;
          end else if (drawWidth != '0) begin
            strb.useSaved = 1'b1;
            stateNext     = ST_HOLD;
            remNext       = drawWidth - ONE;
          end else begin
            stateNext = ST_IDLE;
          end
        end
        default: begin
          kindNext = KIND_STUCK;
          if (drawWidth == '0) begin
            stateNext = ST_IDLE;
          end else begin
            strb.useSaved = 1'b1;
            stateNext     = ST_HOLD;
            remNext       = drawWidth - ONE;
          end
        end
      endcase
    end else if (startEvt) begin
      // A later change overrides any pending delay or glitch
      stateNext = ST_IDLE;
    end else begin
      unique case (state)
        ST_WAIT: begin
          if (rem != '0) begin
            remNext = rem - ONE;
          end else if (widthReg != '0) begin
            strb.useSaved = 1'b1;
            stateNext     = ST_HOLD;
            remNext       = widthReg - ONE;
          end else begin
            stateNext = ST_IDLE;
          end
        end
        ST_HOLD: begin
          if (rem != '0) begin
            strb.useSaved = 1'b1;
            remNext       = rem - ONE;
          end else begin
            stateNext = ST_IDLE;
          end
        end
        default: begin
          stateNext = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      kind     <= KIND_DELAY;
      rem      <= '0;
      widthReg <= '0;
      evtCnt   <= '0;
      invLatch <= 1'b0;
      lfsr     <= SEED;
    end else begin
      state    <= stateNext;
      kind     <= kindNext;
      rem      <= remNext;
      widthReg <= widthNext;
      evtCnt   <= evtCntNext;
      invLatch <= invNext;
      lfsr     <= {1'b0, lfsr[LFSR_W-1:1]} ^ (lfsr[0] ? LFSR_TAPS : '0);
    end
  end

endmodule

// File: rtl/bus_fault_injector.sv
module bus_fault_injector
  import fi_pkg::*;
#(
  parameter int                WIDTH = 16,
  parameter int                CNT_W = 8,
  parameter logic [LFSR_W-1:0] SEED  = 16'hACE1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       cfgMode,
  input  logic [CNT_W-1:0] cfgDelayMin,
  input  logic [CNT_W-1:0] cfgDelayMax,
  input  logic [CNT_W-1:0] cfgWidthMin,
  input  logic [CNT_W-1:0] cfgWidthMax,
  input  logic [CNT_W-1:0] cfgInterval,
  input  logic [WIDTH-1:0] busIn,
  output logic [WIDTH-1:0] busOut
);

  fi_strobe_t       strb;
  logic             changed;
  logic             ctrlIdle;
  logic             invLatch;
  logic             drawFire;
  logic [CNT_W-1:0] drawDelay;

  fi_ctrl #(
    .CNT_W(CNT_W),
    .SEED (SEED)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .changed    (changed),
    .cfgMode    (cfgMode),
    .cfgDelayMin(cfgDelayMin),
    .cfgDelayMax(cfgDelayMax),
    .cfgWidthMin(cfgWidthMin),
    .cfgWidthMax(cfgWidthMax),
    .cfgInterval(cfgInterval),
    .strb       (strb),
    .ctrlIdle   (ctrlIdle),
    .invLatch   (invLatch),
    .drawFire   (drawFire),
    .drawDelay  (drawDelay)
  );

  fi_datapath #(
    .WIDTH(WIDTH)
  ) uData (
    .clk    (clk),
    .rstN   (rstN),
    .busIn  (busIn),
    .strb   (strb),
    .changed(changed),
    .busOut (busOut)
  );

endmodule

// File: rtl/fi_checker.sv
module fi_checker
  import fi_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       cfgMode,
  input logic [CNT_W-1:0] cfgDelayMin,
  input logic [CNT_W-1:0] cfgDelayMax,
  input logic [WIDTH-1:0] busIn,
  input logic [WIDTH-1:0] busOut,
  input logic             ctrlIdle,
  input logic             invLatch,
  input logic             drawFire,
  input logic [CNT_W-1:0] drawDelay
);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (busOut == '0));

  assert_bypass_follow_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == FI_BYPASS && ctrlIdle && !invLatch) |=> (busOut == $past(busIn)));

  assert_jitter_follow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == FI_JITTER && ctrlIdle && !invLatch) |=> (busOut == $past(busIn)));

  assert_invert_bits_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == FI_INVERT && ctrlIdle) |=> (busOut == ~$past(busIn)));

  assert_draw_range_R10: assert property (@(posedge clk) disable iff (!rstN)
    (drawFire && cfgDelayMax != '0 && cfgDelayMax > cfgDelayMin)
      |-> (drawDelay >= cfgDelayMin && drawDelay <= cfgDelayMax));

  assert_draw_fixed_R10: assert property (@(posedge clk) disable iff (!rstN)
    (drawFire && !(cfgDelayMax != '0 && cfgDelayMax > cfgDelayMin))
      |-> (drawDelay == cfgDelayMin));

endmodule

bind bus_fault_injector fi_checker #(
  .WIDTH(WIDTH),
  .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgMode    (cfgMode),
  .cfgDelayMin(cfgDelayMin),
  .cfgDelayMax(cfgDelayMax),
  .busIn      (busIn),
  .busOut     (busOut),
  .ctrlIdle   (ctrlIdle),
  .invLatch   (invLatch),
  .drawFire   (drawFire),
  .drawDelay  (drawDelay)
);

// File: tb/sim_bus_fault_injector.sv
module sim_bus_fault_injector;

  localparam int W = 12;
  localparam int C = 6;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [2:0]   cfgMode = 3'd0;
  logic [C-1:0] cfgDelayMin = '0;
  logic [C-1:0] cfgDelayMax = '0;
  logic [C-1:0] cfgWidthMin = '0;
  logic [C-1:0] cfgWidthMax = '0;
  logic [C-1:0] cfgInterval = C'(1);
  logic [W-1:0] busIn = '0;
  logic [W-1:0] busOut;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bus_fault_injector #(.WIDTH(W), .CNT_W(C)) u0 (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode),
    .cfgDelayMin(cfgDelayMin), .cfgDelayMax(cfgDelayMax),
    .cfgWidthMin(cfgWidthMin), .cfgWidthMax(cfgWidthMax),
    .cfgInterval(cfgInterval), .busIn(busIn), .busOut(busOut)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkRange(input string req, input int act, input int lo, input int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s actual=%0d expected=[%0d..%0d]", req, act, lo, hi);
    end
  endtask

  task automatic doReset(input logic [2:0] m, input int dmin, input int dmax,
                         input int wmin, input int wmax, input int ival);
    @(negedge clk);
    rstN = 1'b0;
    cfgMode = m;
    cfgDelayMin = C'(dmin);
    cfgDelayMax = C'(dmax);
    cfgWidthMin = C'(wmin);
    cfgWidthMax = C'(wmax);
    cfgInterval = C'(ival);
    busIn = '0;
    repeat (3) tick();
    rstN = 1'b1;
  endtask

  task automatic testReset();
    doReset(3'd0, 0, 0, 0, 0, 1);
    chk("R1 during reset", busOut, '0);
    tick();
    chk("R1 after reset", busOut, '0);
  endtask

  task automatic testBypass();
    doReset(3'd0, 5, 9, 4, 6, 1);
    for (int i = 1; i <= 5; i++) begin
      busIn = W'(i * 397);
      tick();
      chk("R2 pass latency", busOut, W'(i * 397));
    end
    busIn = 12'h800;
    tick();
    chk("R2 top bit change", busOut, 12'h800);
  endtask

  task automatic testJitter();
    doReset(3'd3, 3, 0, 2, 0, 1);
    busIn = 12'h3C5;
    tick();
    chk("R3 jitter pass", busOut, 12'h3C5);
    busIn = 12'h0AA;
    tick();
    chk("R3 jitter pass 2", busOut, 12'h0AA);
    cfgMode = 3'd7;
    busIn = 12'h555;
    tick();
    chk("R3 code 7 pass", busOut, 12'h555);
  endtask

  task automatic testDelay();
    doReset(3'd2, 3, 0, 0, 0, 0);
    busIn = 12'h0A5;
    tick(); chk("R5 hold 1", busOut, 12'h000);
    tick(); chk("R5 hold 2", busOut, 12'h000);
    tick(); chk("R5 hold 3", busOut, 12'h000);
    tick(); chk("R5 release", busOut, 12'h0A5);
    tick();
    busIn = 12'h5A0;
    tick(); chk("R4 interval 0 acts as 1", busOut, 12'h0A5);
    tick(); tick();
    tick(); chk("R5 second release", busOut, 12'h5A0);
  endtask

  task automatic testOverride();
    doReset(3'd2, 4, 0, 0, 0, 2);
    busIn = 12'h111;
    tick(); chk("R6 held", busOut, 12'h000);
    tick(); chk("R6 held 2", busOut, 12'h000);
    busIn = 12'h222;
    tick(); chk("R6 override", busOut, 12'h222);
    tick(); chk("R6 after override", busOut, 12'h222);
    busIn = 12'h333;
    tick(); chk("R4 next slot injected", busOut, 12'h222);
  endtask

  task automatic testInterval();
    logic [W-1:0] prev;
    doReset(3'd2, 1, 0, 0, 0, 3);
    prev = '0;
    for (int i = 1; i <= 6; i++) begin
      busIn = W'(i * 17 + 3);
      tick();
      if ((i - 1) % 3 == 0) chk("R4 eligible slot", busOut, prev);
      else chk("R4 skipped slot", busOut, W'(i * 17 + 3));
      tick();
      chk("R4 settled", busOut, W'(i * 17 + 3));
      prev = W'(i * 17 + 3);
    end
  endtask

  task automatic testPulse();
    doReset(3'd1, 2, 0, 2, 0, 1);
    busIn = 12'h7E7;
    tick(); chk("R7 new first", busOut, 12'h7E7);
    tick(); chk("R7 new second", busOut, 12'h7E7);
    tick(); chk("R7 glitch 1", busOut, 12'h000);
    tick(); chk("R7 glitch 2", busOut, 12'h000);
    tick(); chk("R7 restore", busOut, 12'h7E7);
    doReset(3'd1, 0, 0, 1, 0, 1);
    busIn = 12'h124;
    tick(); chk("R7 zero delay glitch", busOut, 12'h000);
    tick(); chk("R7 zero delay restore", busOut, 12'h124);
  endtask

  task automatic testInvert();
    doReset(3'd0, 0, 0, 0, 0, 1);
    busIn = 12'h0F0;
    tick(); chk("R8 before invert", busOut, 12'h0F0);
    cfgMode = 3'd4;
    tick(); chk("R8 invert on entry", busOut, 12'hF0F);
    busIn = 12'h123;
    tick(); chk("R8 invert follows", busOut, 12'hEDC);
    cfgMode = 3'd0;
    tick(); chk("R8 persists after exit", busOut, 12'hEDC);
    tick(); chk("R8 persists 2", busOut, 12'hEDC);
    busIn = 12'h456;
    tick(); chk("R8 released on change", busOut, 12'h456);
  endtask

  task automatic testStuck();
    doReset(3'd5, 0, 0, 3, 0, 1);
    busIn = 12'hABC;
    tick(); chk("R9 freeze 1", busOut, 12'h000);
    busIn = 12'hDEF;
    tick(); chk("R9 change ignored", busOut, 12'h000);
    tick(); chk("R9 freeze 3", busOut, 12'h000);
    tick(); chk("R9 release current", busOut, 12'hDEF);
    doReset(3'd6, 0, 0, 2, 0, 2);
    busIn = 12'h101;
    tick(); chk("R9 freeze new", busOut, 12'h000);
    busIn = 12'h202;
    tick(); chk("R9 ignored in hold", busOut, 12'h000);
    tick(); chk("R9 release", busOut, 12'h202);
    busIn = 12'h303;
    tick(); chk("R9 ignored not counted", busOut, 12'h303);
    busIn = 12'h404;
    tick(); chk("R9 next eligible", busOut, 12'h303);
  endtask

  task automatic measureDelay(input logic [W-1:0] nv, output int n);
    n = 0;
    busIn = nv;
    for (int k = 0; k < 20; k++) begin
      tick();
      if (busOut == nv) break;
      n++;
    end
    tick(); tick();
  endtask

  task automatic testRandom();
    int n;
    int lo;
    int hi;
    doReset(3'd2, 2, 5, 0, 0, 1);
    lo = 99;
    hi = -1;
    for (int t = 1; t <= 16; t++) begin
      measureDelay(W'(t * 211), n);
      chkRange("R10 random delay", n, 2, 5);
      if (n < lo) lo = n;
      if (n > hi) hi = n;
    end
    total++;
    if (lo == hi) begin
      bad++;
      $display("FAIL R10 no variation actual=%0d expected=varied", lo);
    end
    doReset(3'd2, 4, 2, 0, 0, 1);
    for (int t = 1; t <= 3; t++) begin
      measureDelay(W'(t * 99), n);
      chkRange("R10 max below min", n, 4, 4);
    end
    doReset(3'd2, 3, 0, 0, 0, 1);
    measureDelay(12'h9A9, n);
    chkRange("R10 max zero", n, 3, 3);
  endtask

  initial begin
    testReset();
    testBypass();
    testJitter();
    testDelay();
    testOverride();
    testInterval();
    testPulse();
    testInvert();
    testStuck();
    testRandom();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule